// File: doc/BRIEF.md
# Next-Line and Way Predictor

This block keeps one prediction per fetch block of a two-way set-associative instruction cache. Each fetch block holds four instructions. The prediction names the line index and the way of the block to fetch next. The block owns the fetch pointer, which is a line index plus a way. The stored prediction for the block under the pointer is read combinationally and returned in the same cycle, so the next cache access can begin while the correctness check on the current access is still running elsewhere. Tag compare, decode and branch prediction stay outside this loop.

A verify port reports some cycles later whether a given block's prediction was right. A wrong report sends the fetch pointer to the corrected line and way on the next cycle, which costs one cycle. The same report also steps that entry's 2-bit hysteresis counter. The stored prediction is replaced only after the counter has run down to zero, so a single odd outcome does not retrain the entry.

A fill port seeds the entry of a newly filled line with the sequential successor in the same way. A training port writes the target of a register-indirect jump or call straight into the source block's entry. The table has one write port. When several ports write in the same cycle, a fixed priority picks which write is kept.

Top module: `nlw_predictor`

## Requirements
- R1: After reset the fetch pointer is line 0, way 0. Every entry (line L, way W) predicts line (L+1) modulo the line count, way W, with the counter at 1.
- R2: `pred_line`/`pred_way` always show the entry of the block addressed by `fetch_line`/`fetch_way`, in the same cycle.
- R3: With no redirect, `fetch_adv` high loads the current prediction into the fetch pointer on the next edge. Line numbers wrap from the top line to line 0. With `fetch_adv` low the pointer holds.
- R4: A verify with `vfy_ok` low loads `fix_line`/`fix_way` into the fetch pointer on the next edge, whatever the value of `fetch_adv`.
- R5: A fill of (line L, way W) sets that entry to predict line (L+1) modulo the line count, way W, with the counter at 1.
- R6: A training write sets the source entry to the given target line and way, with the counter at 1, whatever it held before.
- R7: A correct verify raises the entry's counter by one, saturating at 3, and leaves its prediction unchanged.
- R8: A wrong verify on an entry whose counter is above 0 lowers the counter by one and keeps the prediction. A wrong verify on an entry whose counter is 0 replaces the prediction with the fix line and way and sets the counter to 1. So an entry with counter 1 is replaced on its second consecutive miss, and an entry with counter 3 on its fourth.
- R9: At most one table write happens per cycle, with the priority fill, then training, then verify. A verify update that loses is dropped, but its redirect (R4) still takes effect.
- R10: A read of an entry in the cycle it is written returns the old contents. The new contents are visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_adv | input | 1 | Advance the fetch pointer to the prediction |
| fetch_line | output | LINE_W | Current fetch line index |
| fetch_way | output | 1 | Current fetch way |
| pred_line | output | LINE_W | Predicted next line for the current block |
| pred_way | output | 1 | Predicted next way for the current block |
| vfy_valid | input | 1 | Verify report valid |
| vfy_line | input | LINE_W | Line of the verified block |
| vfy_way | input | 1 | Way of the verified block |
| vfy_ok | input | 1 | Prediction was correct |
| fix_line | input | LINE_W | Correct next line when wrong |
| fix_way | input | 1 | Correct next way when wrong |
| fill_valid | input | 1 | Cache line fill |
| fill_line | input | LINE_W | Filled line index |
| fill_way | input | 1 | Filled way |
| trn_valid | input | 1 | Indirect jump training write |
| trn_line | input | LINE_W | Line of the jump's block |
| trn_way | input | 1 | Way of the jump's block |
| trn_tgt_line | input | LINE_W | Target line |
| trn_tgt_way | input | 1 | Target way |

## Verification
Assertions check on every cycle the pointer behaviour: redirect on a wrong verify, following the prediction, and holding. They also check that a write becomes visible on the next cycle, that a counter above zero protects the stored prediction from a wrong verify, and that a correct verify saturates the counter. The counter depth, which sets how many misses an entry tolerates, and the priority among colliding writes are visible only over sequences of cycles. The bench's directed scenarios show them, backed by a behavioural model that checks the four outputs on every clock during long random traffic.

// File: rtl/nlw_pkg.sv
package nlw_pkg;
  typedef logic [1:0] hyst_t;
  localparam hyst_t HYST_INIT = 2'd1;
  localparam hyst_t HYST_MAX  = 2'd3;
  localparam hyst_t HYST_MIN  = 2'd0;

  typedef enum logic [1:0] {
    WS_NONE  = 2'd0,
    WS_FILL  = 2'd1,
    WS_TRAIN = 2'd2,
    WS_VFY   = 2'd3
  } wsrc_e;
endpackage

// File: rtl/nlw_rst_sync.sv
module nlw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_q_n = s2_q;
endmodule

// File: rtl/nlw_table.sv
module nlw_table
  import nlw_pkg::*;
#(
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W:0]   fa_idx,
  output logic [LINE_W-1:0] fa_line,
  output logic              fa_way,
  input  logic [LINE_W:0]   vb_idx,
  output logic [LINE_W-1:0] vb_line,
  output logic              vb_way,
  output hyst_t             vb_ctr,
  input  logic              we,
  input  logic [LINE_W:0]   w_idx,
  input  logic [LINE_W+2:0] w_data
);
  localparam int N_LINES = 1 << LINE_W;
  localparam int ENTRIES = 2 * N_LINES;
  localparam int E_W     = LINE_W + 3;

  logic [E_W-1:0] mem_q [ENTRIES];
  logic           past_ok_q;

  function automatic logic [E_W-1:0] seq_init(input int i);
    logic [LINE_W-1:0] ln;
    logic              wy;
    ln = LINE_W'((i % N_LINES) + 1);
    wy = (i >= N_LINES);
    return {ln, wy, HYST_INIT};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= seq_init(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (we && (w_idx == (LINE_W+1)'(i))) mem_q[i] <= w_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  always_comb begin
    fa_line = mem_q[fa_idx][E_W-1:3];
    fa_way  = mem_q[fa_idx][2];
    vb_line = mem_q[vb_idx][E_W-1:3];
    vb_way  = mem_q[vb_idx][2];
    vb_ctr  = mem_q[vb_idx][1:0];
  end

  // R10: a written entry shows the new contents from the next cycle
  a_r10_write_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && we) |=> (mem_q[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/nlw_hyst.sv
module nlw_hyst
  import nlw_pkg::*;
#(
  parameter int LINE_W = 7
) (
  input  logic              ok,
  input  logic [LINE_W-1:0] cur_line,
  input  logic              cur_way,
  input  hyst_t             cur_ctr,
  input  logic [LINE_W-1:0] fix_line,
  input  logic              fix_way,
  output logic [LINE_W-1:0] upd_line,
  output logic              upd_way,
  output hyst_t             upd_ctr
);
  always_comb begin
    upd_line = cur_line;
    upd_way  = cur_way;
    upd_ctr  = cur_ctr;
    if (ok) begin
      if (cur_ctr != HYST_MAX) upd_ctr = cur_ctr + 2'd1;
    end else if (cur_ctr != HYST_MIN) begin
      upd_ctr = cur_ctr - 2'd1;
    end else begin
      upd_line = fix_line;
      upd_way  = fix_way;
      upd_ctr  = HYST_INIT;
    end
  end
endmodule

// File: rtl/nlw_wsel.sv
module nlw_wsel
  import nlw_pkg::*;
#(
  parameter int LINE_W = 7
) (
  input  logic              fill_req,
  input  logic [LINE_W:0]   fill_idx,
  input  logic [LINE_W+2:0] fill_data,
  input  logic              trn_req,
  input  logic [LINE_W:0]   trn_idx,
  input  logic [LINE_W+2:0] trn_data,
  input  logic              vfy_req,
  input  logic [LINE_W:0]   vfy_idx,
  input  logic [LINE_W+2:0] vfy_data,
  output logic              we,
  output logic [LINE_W:0]   w_idx,
  output logic [LINE_W+2:0] w_data,
  output wsrc_e             w_src
);
  always_comb begin
    w_src  = WS_NONE;
    w_idx  = vfy_idx;
    w_data = vfy_data;
    if (fill_req) begin
      w_src  = WS_FILL;
      w_idx  = fill_idx;
      w_data = fill_data;
    end else if (trn_req) begin
      w_src  = WS_TRAIN;
      w_idx  = trn_idx;
      w_data = trn_data;
    end else if (vfy_req) begin
      w_src  = WS_VFY;
    end
    we = (w_src != WS_NONE);
  end
endmodule

// File: rtl/nlw_predictor.sv
module nlw_predictor
  import nlw_pkg::*;
#(
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_adv,
  output logic [LINE_W-1:0] fetch_line,
  output logic              fetch_way,
  output logic [LINE_W-1:0] pred_line,
  output logic              pred_way,
  input  logic              vfy_valid,
  input  logic [LINE_W-1:0] vfy_line,
  input  logic              vfy_way,
  input  logic              vfy_ok,
  input  logic [LINE_W-1:0] fix_line,
  input  logic              fix_way,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_way,
  input  logic              trn_valid,
  input  logic [LINE_W-1:0] trn_line,
  input  logic              trn_way,
  input  logic [LINE_W-1:0] trn_tgt_line,
  input  logic              trn_tgt_way
);
  localparam int IDX_W = LINE_W + 1;
  localparam int E_W   = LINE_W + 3;

  logic              rst_q_n;
  logic [LINE_W-1:0] ptr_line_q, ptr_line_d;
  logic              ptr_way_q, ptr_way_d;
  logic              ptr_en;
  logic              redirect;
  logic              past_ok_q;

  logic [LINE_W-1:0] vrd_line;
  logic              vrd_way;
  hyst_t             vrd_ctr;
  logic [LINE_W-1:0] upd_line;
  logic              upd_way;
  hyst_t             upd_ctr;

  logic              we;
  logic [IDX_W-1:0]  w_idx;
  logic [E_W-1:0]    w_data;
  wsrc_e             w_src;

  nlw_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  nlw_table #(.LINE_W(LINE_W)) i_table (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .fa_idx  ({ptr_way_q, ptr_line_q}),
    .fa_line (pred_line),
    .fa_way  (pred_way),
    .vb_idx  ({vfy_way, vfy_line}),
    .vb_line (vrd_line),
    .vb_way  (vrd_way),
    .vb_ctr  (vrd_ctr),
    .we      (we),
    .w_idx   (w_idx),
    .w_data  (w_data)
  );

  nlw_hyst #(.LINE_W(LINE_W)) i_hyst (
    .ok       (vfy_ok),
    .cur_line (vrd_line),
    .cur_way  (vrd_way),
    .cur_ctr  (vrd_ctr),
    .fix_line (fix_line),
    .fix_way  (fix_way),
    .upd_line (upd_line),
    .upd_way  (upd_way),
    .upd_ctr  (upd_ctr)
  );

  nlw_wsel #(.LINE_W(LINE_W)) i_wsel (
    .fill_req  (fill_valid),
    .fill_idx  ({fill_way, fill_line}),
    .fill_data ({fill_line + LINE_W'(1), fill_way, HYST_INIT}),
    .trn_req   (trn_valid),
    .trn_idx   ({trn_way, trn_line}),
    .trn_data  ({trn_tgt_line, trn_tgt_way, HYST_INIT}),
    .vfy_req   (vfy_valid),
    .vfy_idx   ({vfy_way, vfy_line}),
    .vfy_data  ({upd_line, upd_way, upd_ctr}),
    .we        (we),
    .w_idx     (w_idx),
    .w_data    (w_data),
    .w_src     (w_src)
  );

  // fetch pointer: next state
  always_comb begin
    redirect   = vfy_valid && !vfy_ok;
    ptr_en     = redirect || fetch_adv;
    ptr_line_d = redirect ? fix_line : pred_line;
    ptr_way_d  = redirect ? fix_way  : pred_way;
  end

  // fetch pointer: registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ptr_line_q <= '0;
      ptr_way_q  <= 1'b0;
    end else if (ptr_en) begin
      ptr_line_q <= ptr_line_d;
      ptr_way_q  <= ptr_way_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok_q <= 1'b0;
    else          past_ok_q <= 1'b1;
  end

  assign fetch_line = ptr_line_q;
  assign fetch_way  = ptr_way_q;

  // R4: a wrong verify steers the next fetch to the fix
  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok_q && vfy_valid && !vfy_ok) |=>
      (fetch_line == $past(fix_line) && fetch_way == $past(fix_way)));

  // R3: advancing takes the prediction seen in the same cycle
  a_r3_follow: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok_q && fetch_adv && !(vfy_valid && !vfy_ok)) |=>
      (fetch_line == $past(pred_line) && fetch_way == $past(pred_way)));

  // R3: no advance and no redirect holds the pointer
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok_q && !fetch_adv && !(vfy_valid && !vfy_ok)) |=>
      ($stable(fetch_line) && $stable(fetch_way)));

  // R8: a miss on a counter above zero keeps the stored prediction
  a_r8_keep_on_miss: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok_q && vfy_valid && !vfy_ok && vrd_ctr != 2'd0 && !fill_valid && !trn_valid) |=>
      (!vfy_valid || {vfy_way, vfy_line} != $past({vfy_way, vfy_line}) ||
       (vrd_line == $past(vrd_line) && vrd_way == $past(vrd_way))));

  // R7: a hit raises the counter, saturating at its top value
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok_q && vfy_valid && vfy_ok && !fill_valid && !trn_valid) |=>
      (!vfy_valid || {vfy_way, vfy_line} != $past({vfy_way, vfy_line}) ||
       vrd_ctr == (($past(vrd_ctr) == 2'd3) ? 2'd3 : $past(vrd_ctr) + 2'd1)));
endmodule

// File: tb/test_nlw_predictor.sv
`timescale 1ns/1ps
module test_nlw_predictor;
  localparam int LW = 7;
  localparam int N  = 1 << LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_adv;
  logic [LW-1:0] fetch_line, pred_line;
  logic          fetch_way, pred_way;
  logic          vfy_valid, vfy_way, vfy_ok, fix_way;
  logic [LW-1:0] vfy_line, fix_line;
  logic          fill_valid, fill_way;
  logic [LW-1:0] fill_line;
  logic          trn_valid, trn_way, trn_tgt_way;
  logic [LW-1:0] trn_line, trn_tgt_line;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_line [2][N];
  int m_way  [2][N];
  int m_ctr  [2][N];
  int m_pl, m_pw;

  always #2.5 clk = ~clk;

  nlw_predictor #(.LINE_W(LW)) i_nlw_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_adv(fetch_adv),
    .fetch_line(fetch_line), .fetch_way(fetch_way),
    .pred_line(pred_line), .pred_way(pred_way),
    .vfy_valid(vfy_valid), .vfy_line(vfy_line), .vfy_way(vfy_way), .vfy_ok(vfy_ok),
    .fix_line(fix_line), .fix_way(fix_way),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .trn_valid(trn_valid), .trn_line(trn_line), .trn_way(trn_way),
    .trn_tgt_line(trn_tgt_line), .trn_tgt_way(trn_tgt_way)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle();
    fetch_adv = 0; vfy_valid = 0; vfy_ok = 0; vfy_line = '0; vfy_way = 0;
    fix_line = '0; fix_way = 0; fill_valid = 0; fill_line = '0; fill_way = 0;
    trn_valid = 0; trn_line = '0; trn_way = 0; trn_tgt_line = '0; trn_tgt_way = 0;
  endtask

  task automatic model_reset();
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < N; l++) begin
        m_line[w][l] = (l + 1) % N; m_way[w][l] = w; m_ctr[w][l] = 1;
      end
    m_pl = 0; m_pw = 0;
  endtask

  // behavioural reference: all reads use state from before the edge
  task automatic model_update();
    int ol, ow, c, vl, vw;
    ol = m_line[m_pw][m_pl];
    ow = m_way[m_pw][m_pl];
    vl = int'(vfy_line); vw = int'(vfy_way);
    if (fill_valid) begin
      m_line[fill_way][fill_line] = (int'(fill_line) + 1) % N;
      m_way[fill_way][fill_line]  = int'(fill_way);
      m_ctr[fill_way][fill_line]  = 1;
    end else if (trn_valid) begin
      m_line[trn_way][trn_line] = int'(trn_tgt_line);
      m_way[trn_way][trn_line]  = int'(trn_tgt_way);
      m_ctr[trn_way][trn_line]  = 1;
    end else if (vfy_valid) begin
      c = m_ctr[vw][vl];
      if (vfy_ok) begin
        if (c < 3) m_ctr[vw][vl] = c + 1;
      end else if (c > 0) begin
        m_ctr[vw][vl] = c - 1;
      end else begin
        m_line[vw][vl] = int'(fix_line);
        m_way[vw][vl]  = int'(fix_way);
        m_ctr[vw][vl]  = 1;
      end
    end
    if (vfy_valid && !vfy_ok) begin
      m_pl = int'(fix_line); m_pw = int'(fix_way);
    end else if (fetch_adv) begin
      m_pl = ol; m_pw = ow;
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 per-cycle fetch_line", int'(fetch_line), m_pl);
    chk("R2 R3 per-cycle fetch_way",  int'(fetch_way),  m_pw);
    chk("R2 per-cycle pred_line", int'(pred_line), m_line[m_pw][m_pl]);
    chk("R2 per-cycle pred_way",  int'(pred_way),  m_way[m_pw][m_pl]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic point_to(input int l, input int w);
    idle();
    vfy_valid = 1; vfy_line = LW'(100); vfy_way = 0; vfy_ok = 0;
    fix_line = LW'(l); fix_way = w[0];
    tick();
    idle();
  endtask

  task automatic verify(input int l, input int w, input bit ok, input int fl, input int fw);
    idle();
    vfy_valid = 1; vfy_line = LW'(l); vfy_way = w[0]; vfy_ok = ok;
    fix_line = LW'(fl); fix_way = fw[0];
    tick();
    idle();
  endtask

  task automatic expect_pred(input string tag, input int l, input int w);
    chk({tag, " pred_line"}, int'(pred_line), l);
    chk({tag, " pred_way"},  int'(pred_way),  w);
  endtask

  task automatic expect_fetch(input string tag, input int l, input int w);
    chk({tag, " fetch_line"}, int'(fetch_line), l);
    chk({tag, " fetch_way"},  int'(fetch_way),  w);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    expect_fetch("R1 reset", 0, 0);
    expect_pred("R1 reset", 1, 0);

    // R3 hold with no advance, then advance
    tick();
    expect_fetch("R3 hold", 0, 0);
    fetch_adv = 1; tick(); idle();
    expect_fetch("R3 advance", 1, 0);
    expect_pred("R1 sequential default", 2, 0);

    // R3 wrap at top line; R4 redirect beats advance
    point_to(N - 1, 0);
    expect_pred("R1 top line", 0, 0);
    fetch_adv = 1; tick(); idle();
    expect_fetch("R3 wrap", 0, 0);
    fetch_adv = 1; vfy_valid = 1; vfy_line = LW'(100); vfy_ok = 0;
    fix_line = LW'(33); fix_way = 1; tick(); idle();
    expect_fetch("R4 redirect over advance", 33, 1);

    // R5 fill and R8 counter 1 needs two misses
    fill_valid = 1; fill_line = LW'(5); fill_way = 1; tick(); idle();
    point_to(5, 1);
    expect_pred("R5 fill", 6, 1);
    verify(5, 1, 0, 20, 0);
    expect_fetch("R4 miss redirect", 20, 0);
    point_to(5, 1);
    expect_pred("R8 first miss kept", 6, 1);
    verify(5, 1, 0, 20, 0);
    point_to(5, 1);
    expect_pred("R8 second miss replaced", 20, 0);

    // R7 saturate at 3 then four misses to replace
    for (int k = 0; k < 3; k++) verify(5, 1, 1, 0, 0);
    for (int k = 0; k < 3; k++) verify(5, 1, 0, 30, 1);
    point_to(5, 1);
    expect_pred("R7 saturated counter survives three misses", 20, 0);
    verify(5, 1, 0, 30, 1);
    point_to(5, 1);
    expect_pred("R8 fourth miss replaced", 30, 1);

    // R10 write and read same entry; R6 training
    point_to(70, 1);
    fetch_adv = 1; trn_valid = 1; trn_line = LW'(70); trn_way = 1;
    trn_tgt_line = LW'(3); trn_tgt_way = 0; tick(); idle();
    expect_fetch("R10 old value used", 71, 1);
    point_to(70, 1);
    expect_pred("R6 trained target", 3, 0);

    // R9 fill beats training on same entry
    fill_valid = 1; fill_line = LW'(50); fill_way = 0;
    trn_valid = 1; trn_line = LW'(50); trn_way = 0; trn_tgt_line = LW'(9); trn_tgt_way = 1;
    tick(); idle();
    point_to(50, 0);
    expect_pred("R9 fill wins", 51, 0);

    // R9 verify update dropped under training, redirect kept
    vfy_valid = 1; vfy_line = LW'(60); vfy_way = 0; vfy_ok = 0; fix_line = LW'(9); fix_way = 0;
    trn_valid = 1; trn_line = LW'(90); trn_way = 1; trn_tgt_line = LW'(2); trn_tgt_way = 0;
    tick(); idle();
    expect_fetch("R9 redirect kept", 9, 0);
    verify(60, 0, 0, 9, 0);
    point_to(60, 0);
    expect_pred("R9 dropped verify update", 61, 0);

    // random traffic against the reference model
    for (int k = 0; k < 4000; k++) begin
      idle();
      fetch_adv = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) begin
        vfy_valid = 1; vfy_line = LW'($urandom % N); vfy_way = $urandom % 2;
        vfy_ok = ($urandom % 4) != 0; fix_line = LW'($urandom % N); fix_way = $urandom % 2;
      end
      if (($urandom % 8) == 0) begin
        fill_valid = 1; fill_line = LW'($urandom % N); fill_way = $urandom % 2;
      end
      if (($urandom % 8) == 0) begin
        trn_valid = 1; trn_line = LW'($urandom % N); trn_way = $urandom % 2;
        trn_tgt_line = LW'($urandom % N); trn_tgt_way = $urandom % 2;
      end
      tick();
    end
    idle();
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule